// File: doc/BRIEF.md
# Colour Lookup Table with Byte-Wide Register Port

This block holds a table of colour entries and translates a stream of pixel indices into colours. One index arrives every clock, and the colour stored at that index appears on the colour output one clock later. Each colour is a 9-bit word with three 3-bit channels. Green sits in bits 8:6, red in bits 5:3 and blue in bits 2:0.

A processor loads and inspects the table through an 8-bit register port. The port has three address lines, a chip select and separate active-low read and write strobes. Address bits 2:1 pick one of three 16-bit registers: 0 is the control word, 1 is the table index and 2 is the table data. Address bit 0 picks the low byte (0) or the high byte (1). A low-byte write only lands in a shared holding byte. A high-byte write commits the full word {high, held low} to the register it addresses. The table index advances by one after each high-byte access to the data register, whether a read or a write, so a whole table can be streamed without reloading the index. The control word is stored and presented on an output for the video timing logic elsewhere on the chip.

A small access sequencer makes each strobe assertion act exactly once, however many clocks it lasts. It has three states. BUS_IDLE waits for a selected strobe. On an accepted write it takes transition IDLE_TO_WRITE and performs the write on that edge. On an accepted read it takes IDLE_TO_READ and notes whether the read is a data-high read. BUS_WRITE waits for the strobe to drop and then takes WRITE_TO_IDLE. BUS_READ waits for the strobe to drop and then takes READ_TO_IDLE, and the index advances on that edge if the read was a data-high read.

Top module: `palette_lut`

## Requirements
- R1: After reset the control word is 0, every table entry is 0, the table index is 0, the colour output is 0 and the bus output enable is low.
- R2: A low-byte write (address bit 0 = 0) changes no visible register. A high-byte write to address 1 sets the control word to {written byte, last low byte written}.
- R3: A high-byte write to address 3 sets the table index to bits 8:0 of {written byte, last low byte}. Bits 15:9 are ignored.
- R4: A high-byte write to address 5 stores bits 8:0 of {written byte, last low byte} at the current index, packed green 8:6, red 5:3, blue 2:0. The index then advances by one.
- R5: A selected read of address 4 returns bits 7:0 of the entry at the current index and leaves the index unchanged. A read of address 5 returns bit 8 in bit 0 with bits 7:1 zero, and the index advances by one after the strobe is released.
- R6: The table index wraps from 511 to 0 when it advances.
- R7: The bus output enable is high exactly while chip select and read strobe are low and write strobe is high. Reads of addresses 0 to 3 return 0.
- R8: Strobes with chip select high have no effect on any register and do not enable the bus output.
- R9: The colour output equals the entry at the pixel index sampled on the previous clock edge.
- R10: When a table write and a pixel lookup of the same entry share a clock edge, the colour output shows the old value for that lookup and the new value from the next lookup on.
- R11: A strobe held low for several clocks performs its write or its index advance once.
- R12: Accesses to addresses 6 and 7 change no visible register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register and byte select |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, zero when not enabled |
| rdata_oe | output | 1 | High while the read byte should be driven |
| pix_idx | input | 9 | Pixel colour index |
| pix_color | output | 9 | Colour for the index of the previous clock |
| ctrl_word | output | 16 | Last committed control word |

## Verification
The embedded properties assume that the strobes are synchronous to the clock, and that while a strobe is held the address and chip select stay put. They also assume that read and write are never requested together in a way meant to perform a read, since the write takes precedence. The stimulus drives every bus and pixel input on the falling edge. It keeps the address steady for the whole strobe and releases chip select together with the strobe. It always returns to an idle clock between accesses, so each transition of the sequencer is exercised in isolation. Held strobes of several clocks and accesses with chip select high are the only departures from single-clock strobes, and both stay within these assumptions.

// File: rtl/palette_pkg.sv
package palette_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_t;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_INDEX = 2'd1;
    localparam logic [1:0] SEL_DATA  = 2'd2;

endpackage

// File: rtl/palette_bus_ctl.sv
module palette_bus_ctl
    import palette_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int CW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [15:0]      ctrl_word,
    output logic [IDX_W-1:0] cur_idx,
    output logic             tab_we,
    output logic [CW-1:0]    tab_wdata
);

    bus_state_t       state_q, state_d;
    logic [7:0]       hold_q;
    logic [15:0]      ctrl_q;
    logic [IDX_W-1:0] idx_q;
    logic             rd_hi_q;
    logic [15:0]      word;
    logic             sel_wr, sel_rd, wr_fire, rd_start, rd_end;
    logic [1:0]       reg_sel;
    logic             hi_byte;

    assign sel_wr   = !cs_n && !wr_n;
    assign sel_rd   = !cs_n && !rd_n && wr_n;
    assign reg_sel  = addr[2:1];
    assign hi_byte  = addr[0];
    assign word     = {wdata, hold_q};
    assign wr_fire  = (state_q == BUS_IDLE) && sel_wr;
    assign rd_start = (state_q == BUS_IDLE) && sel_rd;
    assign rd_end   = (state_q == BUS_READ) && !sel_rd;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (sel_wr)      state_d = BUS_WRITE;   // IDLE_TO_WRITE
                else if (sel_rd) state_d = BUS_READ;    // IDLE_TO_READ
            end
            BUS_WRITE: if (!sel_wr) state_d = BUS_IDLE; // WRITE_TO_IDLE
            BUS_READ:  if (!sel_rd) state_d = BUS_IDLE; // READ_TO_IDLE
            default:   state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // register actions tied to transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            ctrl_q  <= '0;
            idx_q   <= '0;
            rd_hi_q <= 1'b0;
        end else begin
            if (wr_fire) begin
                if (!hi_byte) begin
                    hold_q <= wdata;
                end else begin
                    unique case (reg_sel)
                        SEL_CTRL:  ctrl_q <= word;
                        SEL_INDEX: idx_q  <= word[IDX_W-1:0];
                        SEL_DATA:  idx_q  <= idx_q + IDX_W'(1);
                        default:   ;
                    endcase
                end
            end
            if (rd_start) rd_hi_q <= (reg_sel == SEL_DATA) && hi_byte;
            if (rd_end && rd_hi_q) idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign ctrl_word = ctrl_q;
    assign cur_idx   = idx_q;
    assign tab_we    = wr_fire && hi_byte && (reg_sel == SEL_DATA);
    assign tab_wdata = word[CW-1:0];

    p_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && cs_n) |=> ($stable(ctrl_q) && $stable(idx_q)));

    p_held_write_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_WRITE) |=> $stable(idx_q));

    p_low_byte_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !hi_byte) |=> ($stable(ctrl_q) && $stable(idx_q)));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_q == '1) && (tab_we || (rd_end && rd_hi_q))) |=> (idx_q == '0));

endmodule

// File: rtl/palette_store.sv
module palette_store #(
    parameter int IDX_W = 9,
    parameter int CW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [CW-1:0]    wdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [CW-1:0]    pix_color,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic [CW-1:0]    cpu_color
);

    localparam int DEPTH = 1 << IDX_W;

    logic [CW-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[e] <= '0;
            else if (we && waddr == IDX_W'(e))   mem[e] <= wdata;
        end
    end

    // lookup register: reads the value held before this edge's write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_color <= '0;
        else        pix_color <= mem[pix_idx];
    end

    assign cpu_color = mem[cpu_idx];

    p_collide_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == pix_idx) |=> (pix_color == $past(cpu_idx == waddr ? cpu_color : mem[waddr])));

endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
    parameter int IDX_W = 9,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             rdata_oe,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [3*CH_W-1:0] pix_color,
    output logic [15:0]      ctrl_word
);
    import palette_pkg::*;

    localparam int CW = 3 * CH_W;

    logic [IDX_W-1:0] cur_idx;
    logic             tab_we;
    logic [CW-1:0]    tab_wdata;
    logic [CW-1:0]    cpu_color;
    logic [15:0]      cw16;

    palette_bus_ctl #(.IDX_W(IDX_W), .CW(CW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .wdata     (wdata),
        .ctrl_word (ctrl_word),
        .cur_idx   (cur_idx),
        .tab_we    (tab_we),
        .tab_wdata (tab_wdata)
    );

    palette_store #(.IDX_W(IDX_W), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tab_we),
        .waddr     (cur_idx),
        .wdata     (tab_wdata),
        .pix_idx   (pix_idx),
        .pix_color (pix_color),
        .cpu_idx   (cur_idx),
        .cpu_color (cpu_color)
    );

    assign cw16     = 16'(cpu_color);
    assign rdata_oe = !cs_n && !rd_n && wr_n;

    always_comb begin
        rdata = 8'h00;
        if (rdata_oe && addr[2:1] == SEL_DATA)
            rdata = addr[0] ? cw16[15:8] : cw16[7:0];
    end

    p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && addr[2:1] != SEL_DATA) |-> (rdata == 8'h00));

endmodule

// File: tb/tb_palette_lut.sv
module tb_palette_lut;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs_n = 1, rd_n = 1, wr_n = 1;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [8:0] pix_idx = 0;
    logic [8:0] pix_color;
    logic [15:0] ctrl_word;

    int nchk = 0, nerr = 0;
    int m_pal [512];
    int m_idx = 0, m_hold = 0;
    int exp_q = 0;
    bit pin_mode = 0;
    int pin_val = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    palette_lut dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pix_idx(pix_idx), .pix_color(pix_color), .ctrl_word(ctrl_word)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference for the pixel path (R9, R10)
    always @(posedge clk) exp_q <= rst_n ? m_pal[pix_idx] : 0;
    always @(negedge clk) if (rst_n && !done) chk("R9 pixel", int'(pix_color), exp_q);

    initial forever begin
        @(negedge clk);
        if (pin_mode) pix_idx = 9'(pin_val);
        else          pix_idx = pix_idx + 9'd37;
    end

    task automatic model_write(int a, int d);
        if ((a & 1) == 0) m_hold = d;
        else if (a == 3) m_idx = ((d << 8) | m_hold) & 511;
        else if (a == 5) begin
            m_pal[m_idx] = ((d << 8) | m_hold) & 511;
            m_idx = (m_idx + 1) % 512;
        end
    endtask

    task automatic bus_write(int a, int d, int hold_clks = 1);
        @(negedge clk);
        addr = 3'(a); wdata = 8'(d); cs_n = 0; wr_n = 0;
        @(negedge clk);
        model_write(a, d);
        repeat (hold_clks - 1) @(negedge clk);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_read(int a, string tag, int hold_clks = 1);
        int e;
        @(negedge clk);
        addr = 3'(a); cs_n = 0; rd_n = 0;
        #1;
        if (a == 4)      e = m_pal[m_idx] & 255;
        else if (a == 5) e = m_pal[m_idx] >> 8;
        else             e = 0;
        chk({tag, " rdata"}, int'(rdata), e);
        chk("R7 oe on read", int'(rdata_oe), 1);
        repeat (hold_clks) @(negedge clk);
        cs_n = 1; rd_n = 1;
        if (a == 5) m_idx = (m_idx + 1) % 512;
        @(negedge clk);
    endtask

    task automatic set_index(int v);
        bus_write(2, v & 255);
        bus_write(3, v >> 8);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) m_pal[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 colour in reset", int'(pix_color), 0);
        chk("R1 oe in reset", int'(rdata_oe), 0);
        chk("R1 ctrl in reset", int'(ctrl_word), 0);
        rst_n = 1;
        @(negedge clk);
        bus_read(4, "R1 entry0 low");
        bus_read(5, "R1 entry0 high");

        // R2 control word
        bus_write(0, 8'h34);
        chk("R2 low byte alone", int'(ctrl_word), 0);
        bus_write(1, 8'h12);
        chk("R2 control commit", int'(ctrl_word), 16'h1234);

        // R3 index with upper bits ignored, R4 packing
        bus_write(2, 8'h05); bus_write(3, 8'hFF);
        bus_write(4, 8'hAB); bus_write(5, 8'h01);   // G=6 R=5 B=3 -> 0x1AB
        set_index(9'h105);
        bus_read(4, "R4 packed low");
        bus_read(4, "R5 low read no advance");
        bus_read(5, "R4 packed high");
        bus_read(4, "R5 advanced after high read");

        // several patterns streamed from index 0x10
        set_index(16'hFE10);
        for (int i = 0; i < 8; i++) begin
            bus_write(4, (i * 73 + 5) & 255);
            bus_write(5, i & 1);
        end
        set_index(9'h010);
        for (int i = 0; i < 8; i++) begin
            bus_read(4, "R5 stream low");
            bus_read(5, "R5 stream high");
        end

        // R6 wrap on write and on read
        set_index(511);
        bus_write(4, 8'h77); bus_write(5, 8'h01);
        bus_write(4, 8'h3C); bus_write(5, 8'h00);
        set_index(0);
        bus_read(4, "R6 write wrapped to 0");
        set_index(511);
        bus_read(5, "R6 high read at 511");
        bus_read(4, "R6 read wrapped to 0");

        // R7 write-only registers read as zero
        for (int a = 0; a < 4; a++) bus_read(a, "R7 write-only");
        @(negedge clk);
        chk("R7 oe idle", int'(rdata_oe), 0);

        // R8 strobes without chip select
        @(negedge clk);
        addr = 3'd1; wdata = 8'hEE; wr_n = 0;
        @(negedge clk); wr_n = 1; addr = 3'd5; rd_n = 0;
        #1 chk("R8 oe without select", int'(rdata_oe), 0);
        @(negedge clk); rd_n = 1;
        @(negedge clk);
        chk("R8 control untouched", int'(ctrl_word), 16'h1234);
        set_index(0);
        bus_read(4, "R8 index untouched");

        // R11 held strobes act once
        set_index(9'h020);
        bus_write(4, 8'h11); bus_write(5, 8'h01, 4);
        bus_write(4, 8'h22); bus_write(5, 8'h00);
        set_index(9'h020);
        bus_read(5, "R11 held read", 4);
        bus_read(4, "R11 single advance");

        // R12 offsets 6 and 7
        set_index(9'h020);
        bus_write(6, 8'h99); bus_write(7, 8'h88);
        chk("R12 control untouched", int'(ctrl_word), 16'h1234);
        bus_read(4, "R12 index untouched");
        bus_read(6, "R12 read zero");
        bus_read(7, "R12 read zero");

        // R10 collision on entry 0x40
        pin_val = 9'h040; pin_mode = 1;
        set_index(9'h040);
        bus_write(4, 8'h5A);
        @(negedge clk);
        addr = 3'd5; wdata = 8'h01; cs_n = 0; wr_n = 0;
        @(negedge clk);
        chk("R10 old value at collision", int'(pix_color), 0);
        model_write(5, 8'h01);
        cs_n = 1; wr_n = 1;
        @(negedge clk);
        chk("R10 new value next lookup", int'(pix_color), 9'h15A);
        pin_mode = 0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        done = 1;
        nchk++; nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule